// File: doc/BRIEF.md
# Single-Bit Sector Parity Checker and Repairer

This block guards one data sector (512 bytes by default) that is protected by a Hamming-style parity code able to locate and repair one flipped bit. An external accumulator delivers a raw 32-bit parity word. The block turns that word into a 24-bit code and presents it as three bytes, ready to be written next to the sector. When the sector is read back, the caller presents the three stored code bytes and pulses `start`. The block then compares the stored code with the freshly computed one and classifies the outcome.

For a repairable data error the block reports the byte offset and the bit index. If `fix_en` was set with the start pulse, it also flips that bit in the caller's sector buffer. It does this through a byte port with a synchronous one-cycle read latency: one cycle reads the byte, and the next cycle writes it back with the bit flipped. The code is stored inverted. A fully erased sector, whose stored code bytes all read 0xFF, therefore checks clean.

Top module: `sector_ecc_fix`

## Requirements
- R1: The computed code is the inverse of {raw[27:16], raw[11:0]}; raw bits 31:28 and 15:12 are ignored. Its bytes appear on `calc_b0` (code bits 7:0), `calc_b1` (15:8) and `calc_b2` (23:16) one cycle after `raw_parity` is applied.
- R2: The stored code is rebuilt as {stored_b2, stored_b1, stored_b0}. If it equals the computed code, `status` is 0 (clean). This includes an erased sector: raw word 0 and stored bytes all 0xFF.
- R3: Let diff be the computed code XOR the stored code. When diff[23:12] XOR diff[11:0] equals 0xFFF and the offset is in range, `status` is 1 (corrected). In that case `err_off` = diff[23:15] and `err_bit` = diff[14:12].
- R4: A correctable pattern whose offset is not below SECTOR_BYTES gives `status` 3, with `err_off` and `err_bit` set to 0 and the buffer left unchanged. An offset of SECTOR_BYTES-1 is still corrected.
- R5: A diff with exactly one bit set gives `status` 2 (fault in the stored code only), and the buffer is never touched.
- R6: Any other non-zero diff gives `status` 3 (uncorrectable).
- R7: Without a repair, `status`, `err_off`, `err_bit` and a one-cycle `done` pulse all appear in the first cycle after the clock edge that samples `start`.
- R8: With `fix_en` high and `status` 1, the block does three things in order. In cycle 1 it asserts `buf_rd_en` at `buf_addr` = `err_off`. In cycle 2 it asserts `buf_wr_en` with `buf_wdata` = `buf_rdata` XOR (1 << `err_bit`). In cycle 3 it pulses `done`.
- R9: Reset clears `status`, `err_off`, `err_bit` and `done`. Results hold until the next accepted start. A start that arrives while a repair is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_parity | input | 32 | Raw parity word from the accumulator |
| start | input | 1 | One-cycle request to check the sector |
| fix_en | input | 1 | Apply the repair to the buffer, sampled with start |
| stored_b0 | input | 8 | Stored code byte, code bits 7:0 |
| stored_b1 | input | 8 | Stored code byte, code bits 15:8 |
| stored_b2 | input | 8 | Stored code byte, code bits 23:16 |
| calc_b0 | output | 8 | Computed code byte, bits 7:0 |
| calc_b1 | output | 8 | Computed code byte, bits 15:8 |
| calc_b2 | output | 8 | Computed code byte, bits 23:16 |
| done | output | 1 | Check (and repair) finished |
| status | output | 2 | 0 clean, 1 corrected, 2 code-only fault, 3 uncorrectable |
| err_off | output | 9 | Byte offset of the repaired bit |
| err_bit | output | 3 | Bit index inside that byte |
| buf_rd_en | output | 1 | Buffer byte read request |
| buf_addr | output | 9 | Buffer byte address |
| buf_rdata | input | 8 | Buffer read data, valid one cycle after the read |
| buf_wr_en | output | 1 | Buffer byte write strobe |
| buf_wdata | output | 8 | Repaired byte |

## Verification
The computed code bytes are due one cycle after the raw word changes. A verdict without repair is due one cycle after the start edge, and a repaired verdict three cycles after it. The driver records the due cycle of every request in the scoreboard item, computed from its own cycle counter. The monitor compares that due cycle against the cycle in which `done` appears, together with the verdict fields. The bench's buffer model has a one-cycle read latency. After each case, the whole buffer is compared against a shadow copy, which shows any write that should not have happened.

// File: rtl/secfix_pkg.sv
package secfix_pkg;
  localparam int RAW_W  = 32;
  localparam int CODE_W = 24;
  localparam int HALF_W = CODE_W / 2;
  localparam int BYTE_W = 8;
  localparam int NBYTES = CODE_W / BYTE_W;
  localparam int BIT_W  = 3;
  localparam int OFF_W  = CODE_W - HALF_W - BIT_W;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_FIXED = 2'd1,
    ST_CODE  = 2'd2,
    ST_BAD   = 2'd3
  } verdict_t;

  // drop the two reserved nibbles, then invert so erased data matches
  function automatic logic [CODE_W-1:0] squeeze(input logic [RAW_W-1:0] raw);
    return ~{raw[27:16], raw[11:0]};
  endfunction
endpackage

// File: rtl/secfix_pack.sv
module secfix_pack
  import secfix_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [RAW_W-1:0]  raw_parity,
  output logic [CODE_W-1:0] code_q
);
  logic [CODE_W-1:0] code_c;
  assign code_c = squeeze(raw_parity);

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) code_q[b*BYTE_W +: BYTE_W] <= '0;
      else     code_q[b*BYTE_W +: BYTE_W] <= code_c[b*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/secfix_judge.sv
module secfix_judge
  import secfix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              busy,
  input  logic              fix_en,
  input  logic [RAW_W-1:0]  raw_parity,
  input  logic [CODE_W-1:0] stored_code,
  output logic              verdict_vld,
  output logic [1:0]        status,
  output logic [OFF_W-1:0]  err_off,
  output logic [BIT_W-1:0]  err_bit,
  output logic              want_fix
);
  logic [CODE_W-1:0] diff;
  logic [HALF_W-1:0] fold;
  logic [OFF_W-1:0]  loc_off;
  logic [BIT_W-1:0]  loc_bit;
  verdict_t          cls;
  logic              accept;

  assign diff   = squeeze(raw_parity) ^ stored_code;
  assign fold   = diff[CODE_W-1:HALF_W] ^ diff[HALF_W-1:0];
  assign accept = start & ~busy;

  always_comb begin
    cls     = ST_CLEAN;
    loc_off = '0;
    loc_bit = '0;
    if (diff == '0) begin
      cls = ST_CLEAN;
    end else if (fold == '1) begin
      if (32'(diff[CODE_W-1:HALF_W+BIT_W]) < SECTOR_BYTES) begin
        cls     = ST_FIXED;
        loc_off = diff[CODE_W-1:HALF_W+BIT_W];
        loc_bit = diff[HALF_W+BIT_W-1:HALF_W];
      end else begin
        cls = ST_BAD;
      end
    end else if ($onehot(diff)) begin
      cls = ST_CODE;
    end else begin
      cls = ST_BAD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      verdict_vld <= 1'b0;
      status      <= ST_CLEAN;
      err_off     <= '0;
      err_bit     <= '0;
      want_fix    <= 1'b0;
    end else begin
      verdict_vld <= accept;
      if (accept) begin
        status   <= cls;
        err_off  <= loc_off;
        err_bit  <= loc_bit;
        want_fix <= fix_en && (cls == ST_FIXED);
      end
    end
  end

  // R4
  fixed_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    status == ST_FIXED |-> 32'(err_off) < SECTOR_BYTES);

  // R9
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !verdict_vld |-> $stable(status));

  // R3
  fix_needs_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    want_fix |-> status == ST_FIXED);
endmodule

// File: rtl/secfix_patch.sv
module secfix_patch
  import secfix_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              verdict_vld,
  input  logic              want_fix,
  input  logic [1:0]        status,
  input  logic [OFF_W-1:0]  err_off,
  input  logic [BIT_W-1:0]  err_bit,
  output logic              busy,
  output logic              done,
  output logic              buf_rd_en,
  output logic [OFF_W-1:0]  buf_addr,
  input  logic [BYTE_W-1:0] buf_rdata,
  output logic              buf_wr_en,
  output logic [BYTE_W-1:0] buf_wdata
);
  typedef enum logic {P_IDLE, P_WRITE} pstate_t;
  pstate_t state;
  logic    done_q;
  logic    launch;

  assign launch    = verdict_vld & want_fix;
  assign buf_rd_en = launch;
  assign buf_addr  = err_off;
  assign buf_wr_en = (state == P_WRITE);
  assign buf_wdata = buf_rdata ^ (BYTE_W'(1) << err_bit);
  assign busy      = launch | (state == P_WRITE);
  assign done      = (verdict_vld & ~want_fix) | done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= P_IDLE;
      done_q <= 1'b0;
    end else begin
      state  <= launch ? P_WRITE : P_IDLE;
      done_q <= (state == P_WRITE);
    end
  end

  // R8
  write_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    buf_wr_en |-> $past(buf_rd_en));

  // R8
  write_same_addr_chk: assert property (@(posedge clk) disable iff (rst)
    buf_wr_en |-> $stable(buf_addr));

  // R5
  rmw_only_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    buf_rd_en |-> status == 2'd1);

  // R8
  done_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    $past(buf_wr_en) |-> done);
endmodule

// File: rtl/sector_ecc_fix.sv
module sector_ecc_fix
  import secfix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] raw_parity,
  input  logic        start,
  input  logic        fix_en,
  input  logic [7:0]  stored_b0,
  input  logic [7:0]  stored_b1,
  input  logic [7:0]  stored_b2,
  output logic [7:0]  calc_b0,
  output logic [7:0]  calc_b1,
  output logic [7:0]  calc_b2,
  output logic        done,
  output logic [1:0]  status,
  output logic [8:0]  err_off,
  output logic [2:0]  err_bit,
  output logic        buf_rd_en,
  output logic [8:0]  buf_addr,
  input  logic [7:0]  buf_rdata,
  output logic        buf_wr_en,
  output logic [7:0]  buf_wdata
);
  logic [CODE_W-1:0] code_q;
  logic              verdict_vld, want_fix, busy;

  secfix_pack u_pack (
    .clk        (clk),
    .rst        (rst),
    .raw_parity (raw_parity),
    .code_q     (code_q)
  );
  assign calc_b0 = code_q[7:0];
  assign calc_b1 = code_q[15:8];
  assign calc_b2 = code_q[23:16];

  secfix_judge #(.SECTOR_BYTES(SECTOR_BYTES)) u_judge (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .busy        (busy),
    .fix_en      (fix_en),
    .raw_parity  (raw_parity),
    .stored_code ({stored_b2, stored_b1, stored_b0}),
    .verdict_vld (verdict_vld),
    .status      (status),
    .err_off     (err_off),
    .err_bit     (err_bit),
    .want_fix    (want_fix)
  );

  secfix_patch u_patch (
    .clk         (clk),
    .rst         (rst),
    .verdict_vld (verdict_vld),
    .want_fix    (want_fix),
    .status      (status),
    .err_off     (err_off),
    .err_bit     (err_bit),
    .busy        (busy),
    .done        (done),
    .buf_rd_en   (buf_rd_en),
    .buf_addr    (buf_addr),
    .buf_rdata   (buf_rdata),
    .buf_wr_en   (buf_wr_en),
    .buf_wdata   (buf_wdata)
  );
endmodule

// File: tb/sim_sector_ecc_fix.sv
module sim_sector_ecc_fix;
  localparam int SEC = 400;

  logic        clk = 1'b0, rst = 1'b1, start = 1'b0, fix_en = 1'b0;
  logic [31:0] raw_parity = '0;
  logic [7:0]  st0 = '0, st1 = '0, st2 = '0;
  logic [7:0]  calc_b0, calc_b1, calc_b2, buf_wdata;
  logic [7:0]  rd_q = '0;
  logic        done, buf_rd_en, buf_wr_en;
  logic [1:0]  status;
  logic [8:0]  err_off, buf_addr;
  logic [2:0]  err_bit;

  sector_ecc_fix #(.SECTOR_BYTES(SEC)) u0 (
    .clk(clk), .rst(rst), .raw_parity(raw_parity), .start(start), .fix_en(fix_en),
    .stored_b0(st0), .stored_b1(st1), .stored_b2(st2),
    .calc_b0(calc_b0), .calc_b1(calc_b1), .calc_b2(calc_b2),
    .done(done), .status(status), .err_off(err_off), .err_bit(err_bit),
    .buf_rd_en(buf_rd_en), .buf_addr(buf_addr), .buf_rdata(rd_q),
    .buf_wr_en(buf_wr_en), .buf_wdata(buf_wdata)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0] mem [512];
  logic [7:0] exp_mem [512];
  always @(posedge clk) begin
    if (buf_rd_en) rd_q <= mem[buf_addr];
    if (buf_wr_en) mem[buf_addr] <= buf_wdata;
  end

  int total = 0, bad = 0;
  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  typedef struct {
    int         due;
    logic [1:0] st;
    logic [8:0] off;
    logic [2:0] bt;
    string      tag;
  } item_t;
  item_t q[$];

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    item_t it;
    if (!rst && done) begin
      if (q.size() == 0) chk(1'b0, "R9", "done with no pending request", 1, 0);
      else begin
        it = q.pop_front();
        chk(cyc == it.due, it.tag, "done cycle", cyc, it.due);
        chk(status == it.st, it.tag, "status", status, it.st);
        chk(err_off == it.off, it.tag, "err_off", err_off, it.off);
        chk(err_bit == it.bt, it.tag, "err_bit", err_bit, it.bt);
      end
    end
  end

  function automatic logic [31:0] to_raw(input logic [23:0] c);
    logic [23:0] n;
    n = ~c;
    return {4'h0, n[23:12], 4'h0, n[11:0]};
  endfunction

  function automatic logic [23:0] mk_diff(input logic [8:0] off, input logic [2:0] bt);
    logic [11:0] hi;
    hi = {off, bt};
    return {hi, ~hi};
  endfunction

  task automatic drive(input logic [23:0] c, input logic [23:0] s, input bit fen,
                       input logic [1:0] est, input logic [8:0] eoff,
                       input logic [2:0] ebt, input string tag);
    item_t it;
    @(negedge clk);
    raw_parity = to_raw(c);
    {st2, st1, st0} = s;
    fix_en = fen;
    start  = 1'b1;
    it.due = cyc + ((fen && est == 2'd1) ? 3 : 1);
    it.st = est; it.off = eoff; it.bt = ebt; it.tag = tag;
    q.push_back(it);
    if (fen && est == 2'd1) exp_mem[eoff] = exp_mem[eoff] ^ (8'd1 << ebt);
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic mem_chk(input string tag);
    int first = -1;
    for (int i = 0; i < 512; i++)
      if (mem[i] !== exp_mem[i] && first < 0) first = i;
    if (first < 0) chk(1'b1, tag, "buffer", 0, 0);
    else chk(1'b0, tag, "buffer byte", mem[first], exp_mem[first]);
  endtask

  bit finished = 0;
  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    item_t it;
    logic [23:0] c;
    for (int i = 0; i < 512; i++) begin
      mem[i] <= 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(status == 2'd0, "R9", "reset status", status, 0);
    chk(done == 1'b0, "R9", "reset done", done, 0);
    chk(err_off == 9'd0 && err_bit == 3'd0, "R9", "reset location", err_off, 0);
    chk(!buf_rd_en && !buf_wr_en, "R9", "reset buffer strobes", buf_rd_en, 0);
    rst = 1'b0;

    // R1 compression, inversion and byte order
    raw_parity = 32'h1234_5678;
    @(negedge clk);
    chk({calc_b2, calc_b1, calc_b0} == 24'hDCB987, "R1", "calc bytes", {calc_b2, calc_b1, calc_b0}, 24'hDCB987);
    raw_parity = 32'hF000_F000;
    @(negedge clk);
    chk({calc_b2, calc_b1, calc_b0} == 24'hFFFFFF, "R1", "reserved ignored", {calc_b2, calc_b1, calc_b0}, 24'hFFFFFF);
    raw_parity = 32'h0FFF_0FFF;
    @(negedge clk);
    chk({calc_b2, calc_b1, calc_b0} == 24'h000000, "R1", "all kept ones", {calc_b2, calc_b1, calc_b0}, 0);

    // R2 erased sector and matching codes
    drive(24'hFFFFFF, 24'hFFFFFF, 1'b1, 2'd0, 9'd0, 3'd0, "R2");
    drive(24'h5A3C69, 24'h5A3C69, 1'b0, 2'd0, 9'd0, 3'd0, "R2");

    // R3 R8 correct with repair
    c = 24'h5A3C69;
    drive(c, c ^ mk_diff(9'd37, 3'd5), 1'b1, 2'd1, 9'd37, 3'd5, "R8");
    mem_chk("R8");

    // R9 start during repair is ignored
    @(negedge clk);
    raw_parity = to_raw(c);
    {st2, st1, st0} = c ^ mk_diff(9'd12, 3'd7);
    fix_en = 1'b1;
    start  = 1'b1;
    it.due = cyc + 3; it.st = 2'd1; it.off = 9'd12; it.bt = 3'd7; it.tag = "R9";
    q.push_back(it);
    exp_mem[12] = exp_mem[12] ^ 8'h80;
    @(negedge clk);
    {st2, st1, st0} = c ^ 24'h000003;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    chk(status == 2'd1 && err_off == 9'd12, "R9", "status held after ignored start", status, 1);
    mem_chk("R9");

    // R3 R7 correctable, no repair requested
    drive(24'h13579B, 24'h13579B ^ mk_diff(9'd200, 3'd0), 1'b0, 2'd1, 9'd200, 3'd0, "R7");
    mem_chk("R7");

    // R4 offset boundary
    drive(24'h0F0F0F, 24'h0F0F0F ^ mk_diff(9'd399, 3'd3), 1'b1, 2'd1, 9'd399, 3'd3, "R4");
    drive(24'h0F0F0F, 24'h0F0F0F ^ mk_diff(9'd400, 3'd1), 1'b1, 2'd3, 9'd0, 3'd0, "R4");
    drive(24'h0F0F0F, 24'h0F0F0F ^ mk_diff(9'd511, 3'd7), 1'b1, 2'd3, 9'd0, 3'd0, "R4");
    mem_chk("R4");

    // R5 fault in stored code only
    drive(24'hABCDEF, 24'hABCDEF ^ 24'h000100, 1'b1, 2'd2, 9'd0, 3'd0, "R5");
    drive(24'hABCDEF, 24'hABCDEF ^ 24'h800000, 1'b1, 2'd2, 9'd0, 3'd0, "R5");
    mem_chk("R5");

    // R6 uncorrectable patterns
    drive(24'h246802, 24'h246802 ^ 24'h000003, 1'b1, 2'd3, 9'd0, 3'd0, "R6");
    drive(24'h246802, 24'h246802 ^ 24'h12DED3, 1'b1, 2'd3, 9'd0, 3'd0, "R6");
    mem_chk("R6");

    // R9 hold
    repeat (5) @(negedge clk);
    chk(status == 2'd3, "R9", "status held", status, 3);
    chk(q.size() == 0, "R9", "outstanding requests", q.size(), 0);
    finish_run();
  end
endmodule